// File: doc/BRIEF.md
# Line-Addressed Read Port Controller

This block is the read side of a line-organised video store. It keeps a current line number and a preset line number, both 9 bits wide. It changes the current line through a serial address load or through one of four single-cycle line operations. Each time the line changes, it asks the array for that line's image. The returned 768 words of 12 bits are captured into a local read register in a single cycle.

From that register, words stream out one per clock, starting at word 0. A read-enable input moves the word pointer and an output-enable input gates the drive. The data output comes with an output-valid flag that behaves like a tri-state enable.

The array answers a fetch request within the same cycle. It presents the whole line on a wide bus while the request is high, and the block captures it at the closing edge of that cycle.

Top module: `rdp_read_port`

## Requirements
- R1: An address load happens when `addr_en_i`=1 and `mode_sel_i`=0 on 9 consecutive rising edges. Each edge delivers one bit on `addr_ser_i`, most significant bit first. The load sets both the current line and the preset line. A value of 290 or more is clamped to 289. A sequence broken before its 9th bit is discarded and causes no fetch.
- R2: When `mode_sel_i`=1, `step_i`=0 and `addr_en_i`=0 at an edge, the current line is kept and the stream restarts at word 0.
- R3: When `mode_sel_i`=1, `step_i`=0 and `addr_en_i`=1 at an edge, the position goes to line 0, word 0. The preset line is left unchanged, so a later jump returns to it.
- R4: When `mode_sel_i`=1, `step_i`=1 and `addr_en_i`=0 at an edge, the line advances by one and the stream restarts at word 0. At line 289 the line stays at 289.
- R5: When `mode_sel_i`=1, `step_i`=1 and `addr_en_i`=1 at an edge, the position goes to the preset line, word 0.
- R6: A line fetch follows the edge that completes a line operation or an address load. In the next cycle, `fetch_req_o`=1 for one cycle and `fetch_line_o` holds the new line. Word 0 of that line appears on `dout_o` after the closing edge of that cycle.
- R7: With `rd_en_i`=1, the word pointer advances by one at each edge that is not a load, line operation or fetch cycle. With `rd_en_i`=0 the same word keeps being presented.
- R8: With `out_en_i`=0, `dout_oe_o` is 0 and `dout_o` is all zeros, while the pointer still advances under `rd_en_i`.
- R9: The pointer stops at word 767 and stays there while `rd_en_i` remains high.
- R10: `dout_oe_o` is 0 in any cycle where `mode_sel_i`=1, `addr_en_i`=1 or `fetch_req_o`=1.
- R11: After a synchronous reset, the current line and the preset line are 0. Line 0 is fetched in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_sel_i | input | 1 | Selects a line operation cycle |
| step_i | input | 1 | Line operation select bit (next/jump) |
| addr_en_i | input | 1 | Serial address enable; origin/jump select during a line operation |
| addr_ser_i | input | 1 | Serial line address bit, MSB first |
| rd_en_i | input | 1 | Word pointer advance enable |
| out_en_i | input | 1 | Output drive enable |
| fetch_req_o | output | 1 | Line fetch request toward the array |
| fetch_line_o | output | 9 | Line number to fetch |
| line_data_i | input | 9216 | Whole line image, word w at bits [12w+11:12w] |
| dout_o | output | 12 | Streamed word, zero when not valid |
| dout_oe_o | output | 1 | Output-valid / drive enable |

## Verification
Two functions can collide in one cycle: a line operation or address bit, and a pointer advance request. The bench provokes this by holding `rd_en_i` high through every line operation and address load. It then requires that the stream still resumes at word 0 of the new line, and that the output stays invalid throughout. The bench also issues two line steps on back-to-back edges, so that the second operation lands in the fetch cycle of the first. Only the second line may end up presented. Each case is judged from `fetch_line_o`, `dout_oe_o` and the first word streamed afterwards, against a line pattern computed in the bench.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    localparam int DEF_WORD_W     = 12;
    localparam int DEF_LINE_WORDS = 768;
    localparam int DEF_LINE_COUNT = 290;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SHIFT,
        OP_HOLD,
        OP_ORIGIN,
        OP_NEXT,
        OP_JUMP
    } op_e;

    typedef struct packed {
        logic mode_sel;
        logic step;
        logic addr_en;
    } ctl_t;

    function automatic op_e decode_op(ctl_t c);
        op_e r;
        if (c.mode_sel) begin
            case ({c.step, c.addr_en})
                2'b00:   r = OP_HOLD;
                2'b01:   r = OP_ORIGIN;
                2'b10:   r = OP_NEXT;
                default: r = OP_JUMP;
            endcase
        end else if (c.addr_en) begin
            r = OP_SHIFT;
        end else begin
            r = OP_IDLE;
        end
        return r;
    endfunction

    function automatic logic is_line_op(op_e o);
        return (o == OP_HOLD) || (o == OP_ORIGIN) || (o == OP_NEXT) || (o == OP_JUMP);
    endfunction

endpackage

// File: rtl/rdp_addr_shift.sv
module rdp_addr_shift #(
    parameter int AW = 9
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          shift_i,
    input  logic          bit_i,
    output logic          done_o,
    output logic [AW-1:0] val_o
);
    localparam int CW = $clog2(AW + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(AW - 1);

    logic [AW-1:0] sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[AW-2:0], bit_i};
            cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign done_o = shift_i && (cnt_q == LAST_BIT);
    assign val_o  = {sh_q[AW-2:0], bit_i};

    // R1: a load completes only after a run of shift cycles
    a_r1_done_needs_run: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(shift_i));

endmodule

// File: rtl/rdp_line_ctrl.sv
module rdp_line_ctrl
    import rdp_pkg::*;
#(
    parameter int AW    = 9,
    parameter int LINES = 290
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  op_e           op_i,
    input  logic          load_done_i,
    input  logic [AW-1:0] load_val_i,
    output logic          fetch_req_o,
    output logic [AW-1:0] fetch_line_o
);
    localparam logic [AW-1:0] LAST_LINE = AW'(LINES - 1);

    logic [AW-1:0] line_q, preset_q, line_d, load_cl;
    logic          pend_q, go;

    assign load_cl = (load_val_i > LAST_LINE) ? LAST_LINE : load_val_i;
    assign go      = load_done_i || is_line_op(op_i);

    always_comb begin
        line_d = line_q;
        case (op_i)
            OP_ORIGIN: line_d = '0;
            OP_NEXT:   line_d = (line_q == LAST_LINE) ? LAST_LINE : line_q + 1'b1;
            OP_JUMP:   line_d = preset_q;
            default:   line_d = line_q;
        endcase
        if (load_done_i) line_d = load_cl;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            line_q   <= '0;
            preset_q <= '0;
            pend_q   <= 1'b1;
        end else begin
            line_q <= line_d;
            pend_q <= go;
            if (load_done_i) preset_q <= load_cl;
        end
    end

    assign fetch_req_o  = pend_q;
    assign fetch_line_o = line_q;

    // R3: origin leaves the preset untouched
    a_r3_origin_keeps_preset: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_ORIGIN) |=> $stable(preset_q));
    // R2: hold keeps the line
    a_r2_hold_keeps_line: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_HOLD) |=> $stable(fetch_line_o));
    // R4: line never leaves the valid range
    a_r4_line_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch_line_o <= LAST_LINE);
    // R6: every operation is followed by a fetch
    a_r6_fetch_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        go |=> fetch_req_o);

endmodule

// File: rtl/rdp_word_stream.sv
module rdp_word_stream #(
    parameter int W     = 12,
    parameter int WORDS = 768
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [W*WORDS-1:0] line_i,
    input  logic             adv_i,
    output logic [W-1:0]     word_o
);
    localparam int PW = $clog2(WORDS);
    localparam logic [PW-1:0] LAST_WORD = PW'(WORDS - 1);

    logic [W-1:0]  rreg [WORDS];
    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= '0;
        end else if (adv_i && (ptr_q != LAST_WORD)) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (load_i) begin
            for (int w = 0; w < WORDS; w++) begin
                rreg[w] <= line_i[w*W +: W];
            end
        end
    end

    assign word_o = rreg[ptr_q];

    // R9: pointer saturates at the last word
    a_r9_ptr_saturates: assert property (@(posedge clk_i) disable iff (rst_i)
        (ptr_q == LAST_WORD && !load_i) |=> (ptr_q == LAST_WORD));
    // R7: pointer holds without an advance
    a_r7_ptr_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (!adv_i && !load_i) |=> $stable(ptr_q));
    // R6: a fetch restarts at word 0
    a_r6_load_restarts: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (ptr_q == '0));

endmodule

// File: rtl/rdp_read_port.sv
module rdp_read_port
    import rdp_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    parameter int LINE_COUNT = DEF_LINE_COUNT,
    parameter int LINE_AW    = $clog2(LINE_COUNT)
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         mode_sel_i,
    input  logic                         step_i,
    input  logic                         addr_en_i,
    input  logic                         addr_ser_i,
    input  logic                         rd_en_i,
    input  logic                         out_en_i,
    output logic                         fetch_req_o,
    output logic [LINE_AW-1:0]           fetch_line_o,
    input  logic [WORD_W*LINE_WORDS-1:0] line_data_i,
    output logic [WORD_W-1:0]            dout_o,
    output logic                         dout_oe_o
);
    ctl_t               ctl;
    op_e                op;
    logic               load_done, busy, adv;
    logic [LINE_AW-1:0] load_val;
    logic [WORD_W-1:0]  word;

    assign ctl  = '{mode_sel: mode_sel_i, step: step_i, addr_en: addr_en_i};
    assign op   = decode_op(ctl);
    assign busy = (op != OP_IDLE) || fetch_req_o;
    assign adv  = rd_en_i && !busy;

    rdp_addr_shift #(.AW(LINE_AW)) u_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (op == OP_SHIFT),
        .bit_i   (addr_ser_i),
        .done_o  (load_done),
        .val_o   (load_val)
    );

    rdp_line_ctrl #(.AW(LINE_AW), .LINES(LINE_COUNT)) u_line (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .op_i         (op),
        .load_done_i  (load_done),
        .load_val_i   (load_val),
        .fetch_req_o  (fetch_req_o),
        .fetch_line_o (fetch_line_o)
    );

    rdp_word_stream #(.W(WORD_W), .WORDS(LINE_WORDS)) u_stream (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (fetch_req_o),
        .line_i (line_data_i),
        .adv_i  (adv),
        .word_o (word)
    );

    assign dout_oe_o = out_en_i && !busy;
    assign dout_o    = dout_oe_o ? word : '0;

    // R10: no valid output during set, reset or fetch cycles
    a_r10_quiet_when_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_sel_i || addr_en_i || fetch_req_o) |-> !dout_oe_o);
    // R8: disabled drive shows zeros
    a_r8_zero_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !out_en_i |-> (dout_o == '0 && !dout_oe_o));

endmodule

// File: tb/rdp_read_port_tb.sv
module rdp_read_port_tb_top;
    localparam int W = 12, WORDS = 768, AW = 9;

    logic clk = 0, rst = 1;
    logic mode_sel = 0, step = 0, addr_en = 0, addr_ser = 0, rd_en = 0, out_en = 1;
    logic fetch_req, dout_oe;
    logic [AW-1:0] fetch_line;
    logic [W*WORDS-1:0] line_data;
    logic [W-1:0] dout;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rdp_read_port dut_i (
        .clk_i(clk), .rst_i(rst), .mode_sel_i(mode_sel), .step_i(step),
        .addr_en_i(addr_en), .addr_ser_i(addr_ser), .rd_en_i(rd_en), .out_en_i(out_en),
        .fetch_req_o(fetch_req), .fetch_line_o(fetch_line), .line_data_i(line_data),
        .dout_o(dout), .dout_oe_o(dout_oe)
    );

    function automatic logic [W-1:0] pat(int l, int w);
        return W'((l * 41 + w * 7 + 3) % 4096);
    endfunction

    // array model: whole line image of the requested line
    always_comb begin
        for (int w = 0; w < WORDS; w++) line_data[w*W +: W] = pat(int'(fetch_line), w);
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input int l, input int w);
        chk(dout_oe == 1'b1, {req, " valid"}, int'(dout_oe), 1);
        chk(dout == pat(l, w), req, int'(dout), int'(pat(l, w)));
    endtask

    task automatic chk_fetch(input string req, input int l);
        chk(fetch_req == 1'b1, {req, " fetch_req"}, int'(fetch_req), 1);
        chk(fetch_line == AW'(l), {req, " fetch_line"}, int'(fetch_line), l);
        chk(dout_oe == 1'b0, "R10 quiet in fetch", int'(dout_oe), 0);
    endtask

    task automatic t_reset();
        chk_fetch("R11 reset", 0);
        tick();
        chk(fetch_req == 1'b0, "R6 single fetch", int'(fetch_req), 0);
        chk_word("R11 line0 word0", 0, 0);
    endtask

    task automatic t_stream();
        rd_en = 1; tick(); chk_word("R7 adv1", 0, 1);
        tick(); chk_word("R7 adv2", 0, 2);
        rd_en = 0; tick(); tick(); chk_word("R7 hold", 0, 2);
    endtask

    task automatic t_out_en();
        out_en = 0; rd_en = 1; tick();
        chk(dout_oe == 1'b0, "R8 oe low", int'(dout_oe), 0);
        chk(dout == '0, "R8 zero data", int'(dout), 0);
        tick(); out_en = 1; rd_en = 0; #1;
        chk_word("R8 pointer advanced", 0, 4);
    endtask

    // address load with rd_en held high (collision case)
    task automatic t_load(input int v, input int exp);
        mode_sel = 0; addr_en = 1; rd_en = 1;
        for (int i = AW - 1; i >= 0; i--) begin
            addr_ser = v[i];
            #1 chk(dout_oe == 1'b0, "R10 quiet in load", int'(dout_oe), 0);
            tick();
        end
        addr_en = 0; rd_en = 0; #1;
        chk_fetch("R1 load", exp);
        tick();
        chk_word("R1 load word0", exp, 0);
    endtask

    task automatic t_mode(input bit s, input bit a, input int exp, input string req);
        mode_sel = 1; step = s; addr_en = a; rd_en = 1; #1;
        chk(dout_oe == 1'b0, "R10 quiet in mode", int'(dout_oe), 0);
        tick();
        mode_sel = 0; step = 0; addr_en = 0; rd_en = 0; #1;
        chk_fetch(req, exp);
        tick();
        chk_word({req, " word0"}, exp, 0);
    endtask

    task automatic t_back_to_back(input int start);
        mode_sel = 1; step = 1; rd_en = 1; tick(); tick();
        mode_sel = 0; step = 0; rd_en = 0; #1;
        chk_fetch("R4 back-to-back", start + 2);
        tick();
        chk_word("R4 back-to-back word0", start + 2, 0);
    endtask

    task automatic t_partial();
        mode_sel = 0; addr_en = 1; addr_ser = 1;
        for (int i = 0; i < 4; i++) tick();
        addr_en = 0; #1;
        chk(fetch_req == 1'b0, "R1 partial no fetch", int'(fetch_req), 0);
        tick();
        chk(fetch_req == 1'b0, "R1 partial no fetch2", int'(fetch_req), 0);
    endtask

    task automatic t_saturate(input int l);
        rd_en = 1;
        for (int i = 0; i < WORDS + 4; i++) tick();
        chk_word("R9 last word", l, WORDS - 1);
        tick(); tick();
        chk_word("R9 stays", l, WORDS - 1);
        rd_en = 0;
    endtask

    initial begin
        tick(); tick();
        rst = 0; #1;
        t_reset();
        t_stream();
        t_out_en();
        t_load(100, 100);
        rd_en = 1; tick(); tick(); tick(); rd_en = 0;
        t_mode(0, 0, 100, "R2 hold");
        t_mode(1, 0, 101, "R4 next");
        t_mode(0, 1, 0,   "R3 origin");
        t_mode(1, 1, 100, "R5 jump after origin (R3 preset kept)");
        t_load(300, 289);
        t_mode(1, 0, 289, "R4 next saturates");
        t_load(10, 10);
        t_back_to_back(10);
        t_partial();
        t_mode(0, 0, 12, "R1 partial discarded, R2 hold");
        t_load(7, 7);
        t_mode(1, 1, 7, "R5 jump to loaded preset");
        t_saturate(7);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule